// File: doc/BRIEF.md
# Prefixed Shift Execution Unit

This block carries out the one-bit shift group of an 8-bit processor's extended opcode page. A single opcode byte chooses both the shift flavour and the operand. The three flavours are a left shift with zero fill, a right shift that copies the sign bit, and a right shift with zero fill. The operand is one of the working registers of an internal eight-entry register file or, for one selector value, the byte in memory whose address is the H:L register pair. The block produces the shifted byte and the zero, subtract, half-carry and carry flags, and it writes the result back to where the operand came from.

Each instruction is framed by a start pulse and a single-cycle done pulse. Register forms finish in a fixed short count. Memory forms read the byte over a request/acknowledge byte port, write the shifted value back to the same address, and finish in a longer fixed count that grows by one cycle for each memory wait cycle. A host-side port loads and reads the register file between instructions. Opcodes outside the handled groups finish at once with a flag raised and touch nothing.

Top module: `shx_exec_unit`

## Requirements
- R1: Opcode bits [7:3] decide the shift flavour: 5'b00100 (0x20–0x27) is the left shift, 5'b00101 (0x28–0x2F) is the sign-keeping right shift, and 5'b00111 (0x38–0x3F) is the zero-fill right shift. A handled opcode finishes with `unsupported_o` low.
- R2: Opcode bits [2:0] choose the operand: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at H:L, 7=A. These are also the register-file indices on the host port, and index 6 holds the flag register F. A register-form result goes back to the source register, and no other register changes.
- R3: The left shift yields (x << 1) truncated to 8 bits with bit 0 cleared. Carry takes the old bit 7.
- R4: The sign-keeping right shift moves each bit down one place and keeps the old bit 7 in bit 7. Carry takes the old bit 0.
- R5: The zero-fill right shift moves each bit down one place and clears bit 7. Carry takes the old bit 0.
- R6: F holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits [3:0] always read 0, including after a host write. Every handled instruction sets Z exactly when the 8-bit result is 0 and clears N and H.
- R7: For a register form, `done_o` pulses in the 8th cycle after the start edge, with `cycles_o` = 8 during that pulse.
- R8: For a memory form, the block reads at address {H,L}, then writes the shifted byte to the same address. `done_o` pulses in the 16th cycle after the start edge, plus one cycle for each cycle in which a request waits for `mem_ack_i`. `cycles_o` reads 16 in that pulse. A waiting request holds its address and direction.
- R9: Any other opcode (for example 0x30–0x37 or 0x00) pulses `done_o` together with `unsupported_o` in the first cycle after the start edge, with `cycles_o` = 1. It makes no memory request and changes no register or flag.
- R10: While `busy_o` is high, `start_i` and host writes are ignored.
- R11: Reset clears all eight registers and holds `busy_o`, `done_o` and `mem_req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch an instruction (taken when idle) |
| opcode_i | input | 8 | Extended-page opcode sampled with start |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| unsupported_o | output | 1 | With done: opcode not handled |
| cycles_o | output | CNT_W (5) | Nominal cycle count, valid with done |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request direction, 1 = write |
| mem_addr_o | output | 2*DATA_W (16) | Byte address (H:L) |
| mem_wdata_o | output | DATA_W (8) | Write data |
| mem_rdata_i | input | DATA_W (8) | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Completes the current request |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 3 | Host write index |
| host_wdata_i | input | DATA_W (8) | Host write data |
| host_rsel_i | input | 3 | Host read index |
| host_rdata_o | output | DATA_W (8) | Host read data (combinational) |

## Verification
The assertions assume that the memory side acknowledges every request at some point, that read data is valid in the acknowledge cycle, and that the opcode is driven to a known value from reset on. The bench's memory model gives a combinational acknowledge after a programmable number of wait cycles. It returns data from its own byte array and starts with a zero opcode, and it changes inputs only at falling edges. Host writes during an instruction, and a second start during one, are driven on purpose to exercise the ignore rule. They stay within these assumptions, because the design gates both.

// File: rtl/shx_pkg.sv
`timescale 1ns/1ps
package shx_pkg;
   localparam int OPC_W      = 8;
   localparam int SEL_W      = 3;
   localparam int NUM_REGS   = 1 << SEL_W;
   localparam int FLAG_NIB_W = 4;

   localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;  // also index of F in the register file
   localparam logic [SEL_W-1:0] SEL_H   = 3'd4;
   localparam logic [SEL_W-1:0] SEL_L   = 3'd5;

   localparam logic [OPC_W-SEL_W-1:0] GRP_LEFT  = 5'b00100;
   localparam logic [OPC_W-SEL_W-1:0] GRP_ARITH = 5'b00101;
   localparam logic [OPC_W-SEL_W-1:0] GRP_LOGIC = 5'b00111;

   typedef enum logic [1:0] {
      SHK_NONE  = 2'd0,
      SHK_LEFT  = 2'd1,
      SHK_ARITH = 2'd2,
      SHK_LOGIC = 2'd3
   } shift_kind_e;

   typedef struct packed {
      shift_kind_e      kind;
      logic [SEL_W-1:0] sel;
      logic             is_mem;
      logic             legal;
   } shx_dec_t;
endpackage

// File: rtl/shx_decode.sv
`timescale 1ns/1ps
module shx_decode
   import shx_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   output shx_dec_t         dec_o
);
   logic [OPC_W-SEL_W-1:0] grp;
   shift_kind_e            kind;

   assign grp = opcode_i[OPC_W-1:SEL_W];

   always_comb begin
      unique case (grp)
         GRP_LEFT:  kind = SHK_LEFT;
         GRP_ARITH: kind = SHK_ARITH;
         GRP_LOGIC: kind = SHK_LOGIC;
         default:   kind = SHK_NONE;
      endcase
   end

   always_comb begin
      dec_o.kind   = kind;
      dec_o.sel    = opcode_i[SEL_W-1:0];
      dec_o.legal  = (kind != SHK_NONE);
      dec_o.is_mem = (kind != SHK_NONE) && (opcode_i[SEL_W-1:0] == SEL_MEM);
   end
endmodule

// File: rtl/shx_shift.sv
`timescale 1ns/1ps
module shx_shift
   import shx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit USE_BITLOOP = 1'b1
)(
   input  logic [DATA_W-1:0]     operand_i,
   input  shift_kind_e           kind_i,
   output logic [DATA_W-1:0]     result_o,
   output logic [FLAG_NIB_W-1:0] flags_o
);
   logic carry;

   if (DATA_W < 2) begin : g_bad_width
      $error("shx_shift: DATA_W must be at least 2");
   end

   if (USE_BITLOOP) begin : g_bitloop
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic lo_in;
         logic hi_in;
         if (i == 0) begin : g_lsb
            assign lo_in = 1'b0;
         end else begin : g_lo
            assign lo_in = operand_i[i-1];
         end
         if (i == DATA_W-1) begin : g_msb
            assign hi_in = (kind_i == SHK_ARITH) ? operand_i[i] : 1'b0;
         end else begin : g_hi
            assign hi_in = operand_i[i+1];
         end
         assign result_o[i] = (kind_i == SHK_LEFT) ? lo_in :
                              (kind_i == SHK_NONE) ? operand_i[i] : hi_in;
      end
   end else begin : g_vector
      always_comb begin
         unique case (kind_i)
            SHK_LEFT:  result_o = {operand_i[DATA_W-2:0], 1'b0};
            SHK_ARITH: result_o = {operand_i[DATA_W-1], operand_i[DATA_W-1:1]};
            SHK_LOGIC: result_o = {1'b0, operand_i[DATA_W-1:1]};
            default:   result_o = operand_i;
         endcase
      end
   end

   always_comb begin
      unique case (kind_i)
         SHK_LEFT:             carry = operand_i[DATA_W-1];
         SHK_ARITH, SHK_LOGIC: carry = operand_i[0];
         default:              carry = 1'b0;
      endcase
   end

   // Z N H C
   assign flags_o = {(result_o == '0), 1'b0, 1'b0, carry};
endmodule

// File: rtl/shx_regfile.sv
`timescale 1ns/1ps
module shx_regfile
   import shx_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter logic [SEL_W-1:0] FLAG_IDX = SEL_MEM
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SEL_W-1:0]      op_sel_i,
   output logic [DATA_W-1:0]     op_data_o,
   input  logic [SEL_W-1:0]      host_rsel_i,
   output logic [DATA_W-1:0]     host_rdata_o,
   output logic [2*DATA_W-1:0]   hl_o,
   input  logic                  exec_we_i,
   input  logic [SEL_W-1:0]      exec_sel_i,
   input  logic [DATA_W-1:0]     exec_data_i,
   input  logic                  flag_we_i,
   input  logic [FLAG_NIB_W-1:0] flag_nib_i,
   input  logic                  host_we_i,
   input  logic [SEL_W-1:0]      host_sel_i,
   input  logic [DATA_W-1:0]     host_wdata_i
);
   localparam int LOW_W = DATA_W - FLAG_NIB_W;

   if (LOW_W < 1) begin : g_bad_width
      $error("shx_regfile: DATA_W must exceed the flag nibble width");
   end

   logic [DATA_W-1:0] regs_w [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [SEL_W-1:0] IDX = SEL_W'(r);
      logic [DATA_W-1:0] q;
      if (IDX == FLAG_IDX) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (flag_we_i) begin
               q <= {flag_nib_i, {LOW_W{1'b0}}};
            end else if (host_we_i && (host_sel_i == IDX)) begin
               q <= {host_wdata_i[DATA_W-1 -: FLAG_NIB_W], {LOW_W{1'b0}}};
            end
         end
      end else begin : g_data
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (exec_we_i && (exec_sel_i == IDX)) begin
               q <= exec_data_i;
            end else if (host_we_i && (host_sel_i == IDX)) begin
               q <= host_wdata_i;
            end
         end
      end
      assign regs_w[r] = q;
   end

   assign op_data_o    = regs_w[op_sel_i];
   assign host_rdata_o = regs_w[host_rsel_i];
   assign hl_o         = {regs_w[SEL_H], regs_w[SEL_L]};

   AST_F_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      regs_w[FLAG_IDX][LOW_W-1:0] == '0);                                   // R6
   AST_EXEC_NOT_F: assert property (@(posedge clk) disable iff (!rst_n)
      exec_we_i |-> (exec_sel_i != FLAG_IDX));                              // R2
   AST_EXEC_HOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_we_i || flag_we_i) |-> !host_we_i);                             // R10
endmodule

// File: rtl/shx_seq.sv
`timescale 1ns/1ps
module shx_seq
   import shx_pkg::*;
#(
   parameter int REG_CYCLES = 8,
   parameter int MEM_CYCLES = 16,
   parameter int ILL_CYCLES = 1,
   parameter int CNT_W      = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  shx_dec_t         dec_i,
   input  logic             mem_ack_i,
   output logic             busy_o,
   output logic             accept_o,
   output logic             done_o,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic             rd_capture_o,
   output shift_kind_e      kind_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             is_mem_o,
   output logic             illegal_o,
   output logic [CNT_W-1:0] target_o
);
   if (MEM_CYCLES < 3) begin : g_bad_mem
      $error("shx_seq: MEM_CYCLES must leave room for a read and a write");
   end
   if (REG_CYCLES < 1 || ILL_CYCLES < 1) begin : g_bad_reg
      $error("shx_seq: cycle counts must be positive");
   end
   if ((MEM_CYCLES >= (1 << CNT_W)) || (REG_CYCLES >= (1 << CNT_W))
       || (ILL_CYCLES >= (1 << CNT_W))) begin : g_bad_cnt
      $error("shx_seq: CNT_W too narrow for the cycle counts");
   end

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target_q;
   logic             rd_done_q;
   logic             wr_done_q;
   shift_kind_e      kind_q;
   logic [SEL_W-1:0] sel_q;
   logic             is_mem_q;
   logic             illegal_q;
   logic             stall;

   assign accept_o     = start_i && !busy_q;
   assign mem_req_o    = busy_q && is_mem_q && !wr_done_q;
   assign mem_we_o     = mem_req_o && rd_done_q;
   assign stall        = mem_req_o && !mem_ack_i;
   assign rd_capture_o = mem_req_o && !rd_done_q && mem_ack_i;
   assign done_o       = busy_q && (cnt_q == target_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         target_q  <= '0;
         rd_done_q <= 1'b0;
         wr_done_q <= 1'b0;
         kind_q    <= SHK_NONE;
         sel_q     <= '0;
         is_mem_q  <= 1'b0;
         illegal_q <= 1'b0;
      end else if (accept_o) begin
         busy_q    <= 1'b1;
         cnt_q     <= CNT_W'(1);
         rd_done_q <= 1'b0;
         wr_done_q <= 1'b0;
         kind_q    <= dec_i.kind;
         sel_q     <= dec_i.sel;
         is_mem_q  <= dec_i.is_mem;
         illegal_q <= !dec_i.legal;
         if (!dec_i.legal)
            target_q <= CNT_W'(ILL_CYCLES);
         else if (dec_i.is_mem)
            target_q <= CNT_W'(MEM_CYCLES);
         else
            target_q <= CNT_W'(REG_CYCLES);
      end else if (busy_q) begin
         if (done_o) begin
            busy_q <= 1'b0;
         end else if (!stall) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (mem_req_o && mem_ack_i) begin
            if (!rd_done_q) rd_done_q <= 1'b1;
            else            wr_done_q <= 1'b1;
         end
      end
   end

   assign busy_o    = busy_q;
   assign kind_o    = kind_q;
   assign sel_o     = sel_q;
   assign is_mem_o  = is_mem_q;
   assign illegal_o = illegal_q;
   assign target_o  = target_q;

   // Independent elapsed/wait counters used only by the checks below.
   int el_q;
   int wt_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         el_q <= 0;
         wt_q <= 0;
      end else if (accept_o) begin
         el_q <= 1;
         wt_q <= 0;
      end else if (busy_q) begin
         el_q <= el_q + 1;
         if (mem_req_o && !mem_ack_i) wt_q <= wt_q + 1;
      end
   end

   AST_REG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !is_mem_q && !illegal_q) |-> (el_q == REG_CYCLES));        // R7
   AST_MEM_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && is_mem_q) |-> (el_q == MEM_CYCLES + wt_q));                // R8
   AST_ILL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && illegal_q) |-> (el_q == ILL_CYCLES));                      // R9
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o)));      // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done_o && start_i) |=>
         (busy_q && $stable(sel_q) && $stable(kind_q)));                    // R10
   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(!rst_n) |-> (!busy_q && !mem_req_o));                           // R11
endmodule

// File: rtl/shx_exec_unit.sv
`timescale 1ns/1ps
module shx_exec_unit
   import shx_pkg::*;
#(
   parameter int  DATA_W      = 8,
   parameter int  REG_CYCLES  = 8,
   parameter int  MEM_CYCLES  = 16,
   parameter int  ILL_CYCLES  = 1,
   parameter bit  USE_BITLOOP = 1'b1,
   localparam int ADDR_W      = 2 * DATA_W,
   localparam int CNT_W       = $clog2(MEM_CYCLES + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OPC_W-1:0]  opcode_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              unsupported_o,
   output logic [CNT_W-1:0]  cycles_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ack_i,
   input  logic              host_we_i,
   input  logic [SEL_W-1:0]  host_sel_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   input  logic [SEL_W-1:0]  host_rsel_i,
   output logic [DATA_W-1:0] host_rdata_o
);
   shx_dec_t              dec;
   logic                  accept;
   logic                  rd_capture;
   shift_kind_e           kind_q;
   logic [SEL_W-1:0]      sel_q;
   logic                  is_mem_q;
   logic                  illegal_q;
   logic [CNT_W-1:0]      target;
   logic [DATA_W-1:0]     op_data;
   logic [DATA_W-1:0]     operand_q;
   logic [DATA_W-1:0]     result;
   logic [FLAG_NIB_W-1:0] flags;
   logic [ADDR_W-1:0]     hl;
   logic                  exec_we;
   logic                  flag_we;
   logic                  host_we_gated;

   shx_decode u_decode (
      .opcode_i (opcode_i),
      .dec_o    (dec)
   );

   shx_seq #(
      .REG_CYCLES (REG_CYCLES),
      .MEM_CYCLES (MEM_CYCLES),
      .ILL_CYCLES (ILL_CYCLES),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .dec_i        (dec),
      .mem_ack_i    (mem_ack_i),
      .busy_o       (busy_o),
      .accept_o     (accept),
      .done_o       (done_o),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .rd_capture_o (rd_capture),
      .kind_o       (kind_q),
      .sel_o        (sel_q),
      .is_mem_o     (is_mem_q),
      .illegal_o    (illegal_q),
      .target_o     (target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          operand_q <= '0;
      else if (accept)     operand_q <= op_data;
      else if (rd_capture) operand_q <= mem_rdata_i;
   end

   shx_shift #(
      .DATA_W      (DATA_W),
      .USE_BITLOOP (USE_BITLOOP)
   ) u_shift (
      .operand_i (operand_q),
      .kind_i    (kind_q),
      .result_o  (result),
      .flags_o   (flags)
   );

   assign exec_we       = done_o && !illegal_q && !is_mem_q;
   assign flag_we       = done_o && !illegal_q;
   assign host_we_gated = host_we_i && !busy_o;

   shx_regfile #(
      .DATA_W   (DATA_W),
      .FLAG_IDX (SEL_MEM)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_sel_i     (dec.sel),
      .op_data_o    (op_data),
      .host_rsel_i  (host_rsel_i),
      .host_rdata_o (host_rdata_o),
      .hl_o         (hl),
      .exec_we_i    (exec_we),
      .exec_sel_i   (sel_q),
      .exec_data_i  (result),
      .flag_we_i    (flag_we),
      .flag_nib_i   (flags),
      .host_we_i    (host_we_gated),
      .host_sel_i   (host_sel_i),
      .host_wdata_i (host_wdata_i)
   );

   assign mem_addr_o    = hl;
   assign mem_wdata_o   = result;
   assign unsupported_o = done_o && illegal_q;
   assign cycles_o      = done_o ? target : '0;

   AST_DEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dec.legal |-> (opcode_i[7:6] == 2'b00 && opcode_i[5]));               // R1
   AST_UNSUP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported_o |-> !mem_req_o);                                        // R9
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));             // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                  // R7
endmodule

// File: tb/shx_exec_unit_tb.sv
`timescale 1ns/1ps
module shx_exec_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  opcode_i = 8'h00;
   logic        busy_o, done_o, unsupported_o;
   logic [4:0]  cycles_o;
   logic        mem_req_o, mem_we_o;
   logic [15:0] mem_addr_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  mem_rdata_i;
   logic        mem_ack_i;
   logic        host_we_i = 1'b0;
   logic [2:0]  host_sel_i = 3'd0;
   logic [7:0]  host_wdata_i = 8'h00;
   logic [2:0]  host_rsel_i = 3'd0;
   logic [7:0]  host_rdata_o;

   always #5 clk = ~clk;  // 100 MHz

   shx_exec_unit dut_i (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .opcode_i (opcode_i),
      .busy_o (busy_o), .done_o (done_o), .unsupported_o (unsupported_o),
      .cycles_o (cycles_o), .mem_req_o (mem_req_o), .mem_we_o (mem_we_o),
      .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
      .mem_rdata_i (mem_rdata_i), .mem_ack_i (mem_ack_i),
      .host_we_i (host_we_i), .host_sel_i (host_sel_i),
      .host_wdata_i (host_wdata_i), .host_rsel_i (host_rsel_i),
      .host_rdata_o (host_rdata_o)
   );

   // ---------------- memory model ----------------
   logic [7:0]  mem_q [256];
   logic [3:0]  wcnt = 4'd0;
   logic [3:0]  wait_cfg = 4'd0;
   logic        pk_en = 1'b0;
   logic [7:0]  pk_addr = 8'h00;
   logic [7:0]  pk_data = 8'h00;
   logic        saw_req = 1'b0;
   logic        clr_req = 1'b0;
   logic [15:0] rd_addr_seen = 16'h0;
   logic [15:0] wr_addr_seen = 16'h0;

   assign mem_ack_i   = mem_req_o && (wcnt == wait_cfg);
   assign mem_rdata_i = mem_q[mem_addr_o[7:0]];

   always @(posedge clk) begin
      if (pk_en) mem_q[pk_addr] <= pk_data;
      if (mem_req_o && !mem_ack_i) wcnt <= wcnt + 4'd1;
      else                         wcnt <= 4'd0;
      if (mem_req_o && mem_ack_i && !mem_we_o) rd_addr_seen <= mem_addr_o;
      if (mem_req_o && mem_ack_i && mem_we_o) begin
         mem_q[mem_addr_o[7:0]] <= mem_wdata_o;
         wr_addr_seen <= mem_addr_o;
      end
      if (mem_req_o)    saw_req <= 1'b1;
      else if (clr_req) saw_req <= 1'b0;
   end

   // ---------------- bookkeeping ----------------
   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] shadow [8];

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input logic [2:0] sel, input logic [7:0] data);
      @(negedge clk);
      host_we_i = 1'b1; host_sel_i = sel; host_wdata_i = data;
      @(negedge clk);
      host_we_i = 1'b0;
      shadow[sel] = (sel == 3'd6) ? {data[7:4], 4'h0} : data;
   endtask

   task automatic host_read(input logic [2:0] sel, output logic [7:0] data);
      host_rsel_i = sel;
      #1;
      data = host_rdata_o;
   endtask

   task automatic mem_poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pk_en = 1'b1; pk_addr = a; pk_data = d;
      @(negedge clk);
      pk_en = 1'b0;
   endtask

   task automatic load_pattern();
      for (int k = 0; k < 8; k++) begin
         if (k == 6) host_write(3'(k), 8'hFF);
         else        host_write(3'(k), 8'(8'h11 * (k + 1)));
      end
   endtask

   task automatic check_regs(input string req);
      logic [7:0] v;
      for (int k = 0; k < 8; k++) begin
         host_read(3'(k), v);
         chk(req, $sformatf("reg[%0d]", k), v, shadow[k]);
      end
   endtask

   // Launch one instruction; n = cycles from start edge to done (inclusive).
   task automatic run_op(input logic [7:0] op, output int n,
                         output logic [4:0] cyc, output logic uns);
      @(negedge clk);
      start_i = 1'b1; opcode_i = op;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      while (!done_o && n < 100) begin
         @(negedge clk);
         n++;
      end
      cyc = cycles_o;
      uns = unsupported_o;
      @(negedge clk);
   endtask

   // opcode, operand, result, F
   localparam logic [31:0] VEC [15] = '{
      32'h20_85_0A_10, 32'h21_80_00_90, 32'h27_41_82_00, 32'h25_FF_FE_10,
      32'h23_00_00_80, 32'h28_81_C0_10, 32'h2A_01_00_90, 32'h2F_7E_3F_00,
      32'h2D_80_C0_00, 32'h38_81_40_10, 32'h3B_FF_7F_10, 32'h3C_00_00_80,
      32'h26_C3_86_10, 32'h2E_80_C0_00, 32'h3E_01_00_90
   };

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      int n;
      logic [4:0] cyc;
      logic uns;
      logic [7:0] v;

      for (int k = 0; k < 8; k++) shadow[k] = 8'h00;

      // ---- R11: reset state ----
      repeat (3) @(negedge clk);
      chk("R11", "busy_o in reset", busy_o, 0);
      chk("R11", "done_o in reset", done_o, 0);
      chk("R11", "mem_req_o in reset", mem_req_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_regs("R11");

      // ---- table of vectors ----
      for (int i = 0; i < 15; i++) begin
         logic [7:0] op, opnd, res, fl;
         string kreq;
         bit is_mem;
         int ecyc;
         {op, opnd, res, fl} = VEC[i];
         is_mem = (op[2:0] == 3'd6);
         ecyc   = is_mem ? 16 : 8;
         case (op[4:3])
            2'b00:   kreq = "R3";
            2'b01:   kreq = "R4";
            default: kreq = "R5";
         endcase
         load_pattern();
         if (i == 0) begin
            host_read(3'd6, v);
            chk("R6", "F low nibble after host write", v, 8'hF0);
         end
         if (is_mem) begin
            host_write(3'd4, 8'h12);
            host_write(3'd5, 8'h34);
            mem_poke(8'h34, opnd);
         end else begin
            host_write(op[2:0], opnd);
         end
         run_op(op, n, cyc, uns);
         chk("R1", $sformatf("op %02h unsupported_o", op), uns, 0);
         chk(is_mem ? "R8" : "R7", $sformatf("op %02h done latency", op), n, ecyc);
         chk(is_mem ? "R8" : "R7", $sformatf("op %02h cycles_o", op), cyc, ecyc);
         if (is_mem) begin
            chk(kreq, $sformatf("op %02h memory result", op), mem_q[8'h34], res);
            chk("R8", "read address", rd_addr_seen, 16'h1234);
            chk("R8", "write address", wr_addr_seen, 16'h1234);
         end else begin
            shadow[op[2:0]] = res;
         end
         host_read(3'd6, v);
         chk("R6", $sformatf("op %02h flags", op), v, fl);
         shadow[6] = fl;
         check_regs("R2");
      end

      // ---- R9: unsupported opcodes ----
      for (int j = 0; j < 2; j++) begin
         logic [7:0] bad;
         bad = (j == 0) ? 8'h30 : 8'h00;
         load_pattern();
         host_write(3'd4, 8'h12);
         host_write(3'd5, 8'h34);
         @(negedge clk);
         clr_req = 1'b1;
         @(negedge clk);
         clr_req = 1'b0;
         run_op(bad, n, cyc, uns);
         chk("R9", $sformatf("op %02h unsupported_o", bad), uns, 1);
         chk("R9", $sformatf("op %02h latency", bad), n, 1);
         chk("R9", $sformatf("op %02h cycles_o", bad), cyc, 1);
         chk("R9", $sformatf("op %02h memory request seen", bad), saw_req, 0);
         check_regs("R9");
      end

      // ---- R10: start and host write ignored while busy ----
      load_pattern();
      host_write(3'd0, 8'h81);
      @(negedge clk);
      start_i = 1'b1; opcode_i = 8'h20;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      @(negedge clk);
      n++;
      start_i = 1'b1; opcode_i = 8'h38;
      host_we_i = 1'b1; host_sel_i = 3'd1; host_wdata_i = 8'hEE;
      @(negedge clk);
      n++;
      start_i = 1'b0; host_we_i = 1'b0;
      while (!done_o && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R10", "first instruction latency", n, 8);
      @(negedge clk);
      chk("R10", "no relaunch after done", busy_o, 0);
      shadow[0] = 8'h02;
      shadow[6] = 8'h10;
      check_regs("R10");

      // ---- R8: memory form with wait states ----
      load_pattern();
      host_write(3'd4, 8'h12);
      host_write(3'd5, 8'h34);
      mem_poke(8'h34, 8'h02);
      wait_cfg = 4'd2;
      run_op(8'h3E, n, cyc, uns);
      wait_cfg = 4'd0;
      chk("R8", "latency with two waits per access", n, 20);
      chk("R8", "cycles_o with waits", cyc, 16);
      chk("R5", "memory zero-fill right result", mem_q[8'h34], 8'h01);
      host_read(3'd6, v);
      chk("R6", "flags after memory shift", v, 8'h00);

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule